// File: doc/BRIEF.md
# Servo Error Offset Calibration Unit

This block sits between the sample converters of an optical-disc servo front end and the servo filters. It takes four signed sample channels on a shared sample strobe: the centre reference level, the focus error, the tracking error and the RF envelope. On a measurement command it averages one chosen channel over 256 consecutive strobes and stores the result as that channel's DC offset. While the measurement runs, the sense output stays high. When the sense output falls, the stored value is ready.

A second command kind latches a word of compensation enables. Each output path subtracts a stored average from its live sample when its enable is set. The tracking and focus paths can use either the centre-reference average or their own channel's average. A separate focus-zero-cross path always uses the focus average. Signed results saturate at the ends of the sample range. The RF path gives the non-negative excess of the sample over its average. A path whose enable is clear passes its raw sample through unchanged. The outputs are registered on each sample strobe.

Top module: `servo_offset_cal`

## Requirements
- R1: A measurement of a channel stores floor(sum of that channel's samples on 256 consecutive strobes / 256). The stored value is kept until the same channel is measured again.
- R2: A measurement command (cmd_valid with cmd_is_comp=0) selects its channel from cmd_word. Bit 15 selects centre reference, bit 13 focus, bit 11 RF and bit 4 tracking. If several of these bits are set, the priority is centre > focus > RF > tracking. A command with none of these bits set is ignored.
- R3: A measurement command that arrives while sense is high is ignored, and the current measurement completes normally. Such a command sets cmd_err, which stays set until reset.
- R4: sense rises in the cycle after an accepted measurement command. It stays high for exactly 256 strobes and falls in the cycle after the 256th strobe.
- R5: With compensation bit 0 set, rf_out is rf_smp minus the RF average when the sample is above the average. Otherwise it is 0. The output is unsigned.
- R6: Compensation bit 1 makes trk_out equal te_smp minus the centre average. Bit 2 makes it te_smp minus the tracking average. Bit 2 wins if both bits are set.
- R7: Compensation bit 3 makes fcs_out equal fe_smp minus the centre average. Bit 4 makes it fe_smp minus the focus average. Bit 4 wins if both bits are set.
- R8: Compensation bit 5 makes fzc_out equal fe_smp minus the focus average.
- R9: A path whose compensation bits are all clear outputs its raw sample. For rf_out, this is the sample's two's-complement bits.
- R10: Signed differences saturate to the range -128..127 instead of wrapping.
- R11: Outputs change only in the cycle after a strobe and hold otherwise. A compensation command (cmd_is_comp=1) latches cmd_word[5:0] at any time, including while a measurement runs.
- R12: After reset, sense, cmd_err, all outputs and all stored averages are zero, and all compensation bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one cycle per sample set |
| vc_smp | input | 8 | Centre reference sample, signed |
| fe_smp | input | 8 | Focus error sample, signed |
| te_smp | input | 8 | Tracking error sample, signed |
| rf_smp | input | 8 | RF envelope sample, signed |
| cmd_valid | input | 1 | Command strobe |
| cmd_is_comp | input | 1 | 1 = compensation word, 0 = measurement |
| cmd_word | input | 16 | Command word |
| sense | output | 1 | High while a measurement runs |
| cmd_err | output | 1 | Sticky flag for a measurement command that arrived while busy |
| fcs_out | output | 8 | Focus input value, signed |
| trk_out | output | 8 | Tracking input value, signed |
| fzc_out | output | 8 | Focus-zero-cross value, signed |
| rf_out | output | 8 | RF value, unsigned when compensated |

## Verification
The bench sweeps every sample value through each compensation mode. This exposes a subtractor that wraps instead of saturating at either end, and an RF path that goes negative or is off by one at the average. It also exposes a path that picks the wrong average when both of its select bits are set. A measurement command is sent in the middle of another measurement. A design that restarts or retargets would change the sense length or the stored averages, and one that does not flag the command would leave cmd_err low. A command with three channel bits set checks the priority: a wrong decode changes the tracking or RF result afterwards. The sense length is counted in strobes to catch an accumulator that stops one sample early or late.

// File: rtl/servo_cal_pkg.sv
// Shared constants and types for the servo offset calibration unit.
package servo_cal_pkg;
    typedef enum logic [1:0] {
        CH_VC = 2'd0,
        CH_FE = 2'd1,
        CH_TE = 2'd2,
        CH_RF = 2'd3
    } cal_ch_e;

    localparam int CMD_W  = 16;
    localparam int BIT_VC = 15;
    localparam int BIT_FE = 13;
    localparam int BIT_RF = 11;
    localparam int BIT_TE = 4;

    // Packed with the MSB first: bit0 rf_clip ... bit5 fzc_fe
    typedef struct packed {
        logic fzc_fe;
        logic fcs_fe;
        logic fcs_vc;
        logic trk_te;
        logic trk_vc;
        logic rf_clip;
    } comp_en_t;

    localparam int COMP_W = $bits(comp_en_t);
endpackage

// File: rtl/cal_meas_engine.sv
// Measurement engine: decodes a measurement command and accumulates
// 2**LOG2N strobed samples of one channel. It stores the floor average
// per channel.
// Assumes: one measurement at a time; a command while busy is dropped and
// flagged.
module cal_meas_engine
    import servo_cal_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LOG2N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] vc_in,
    input  logic signed [DW-1:0] fe_in,
    input  logic signed [DW-1:0] te_in,
    input  logic signed [DW-1:0] rf_in,
    input  logic                 meas_req,
    input  logic [3:0]           meas_bits,   // {vc, fe, rf, te}
    output logic                 busy,
    output logic                 err,
    output logic signed [DW-1:0] avg_vc,
    output logic signed [DW-1:0] avg_fe,
    output logic signed [DW-1:0] avg_te,
    output logic signed [DW-1:0] avg_rf
);
    localparam int AW = DW + LOG2N;
    localparam logic [LOG2N-1:0] LAST = {LOG2N{1'b1}};

    logic                  busy_q, err_q;
    cal_ch_e               ch_q, sel_ch;
    logic                  has_req;
    logic [LOG2N-1:0]      cnt_q;
    logic signed [AW-1:0]  acc_q, acc_sum, acc_avg;
    logic signed [DW-1:0]  cur_smp;
    logic signed [DW-1:0]  avg_q [4];

    // Priority decode of the requested channel
    always_comb begin
        has_req = |meas_bits;
        if (meas_bits[3])      sel_ch = CH_VC;
        else if (meas_bits[2]) sel_ch = CH_FE;
        else if (meas_bits[1]) sel_ch = CH_RF;
        else                   sel_ch = CH_TE;
    end

    // Select the sample of the channel under measurement
    always_comb begin
        case (ch_q)
            CH_VC:   cur_smp = vc_in;
            CH_FE:   cur_smp = fe_in;
            CH_TE:   cur_smp = te_in;
            default: cur_smp = rf_in;
        endcase
    end

    // Running sum plus the current sample, and its arithmetic-shift average
    always_comb begin
        acc_sum = acc_q + {{LOG2N{cur_smp[DW-1]}}, cur_smp};
        acc_avg = acc_sum >>> LOG2N;
    end

    // Command acceptance, accumulation and storage of the average
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            ch_q   <= CH_VC;
            cnt_q  <= '0;
            acc_q  <= '0;
            for (int i = 0; i < 4; i++) avg_q[i] <= '0;
        end else begin
            if (meas_req && has_req) begin
                if (busy_q) begin
                    err_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    ch_q   <= sel_ch;
                    cnt_q  <= '0;
                    acc_q  <= '0;
                end
            end
            if (busy_q && smp_stb) begin
                if (cnt_q == LAST) begin
                    avg_q[ch_q] <= acc_avg[DW-1:0];
                    busy_q      <= 1'b0;
                    cnt_q       <= '0;
                    acc_q       <= '0;
                end else begin
                    acc_q <= acc_sum;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy   = busy_q;
    assign err    = err_q;
    assign avg_vc = avg_q[0];
    assign avg_fe = avg_q[1];
    assign avg_te = avg_q[2];
    assign avg_rf = avg_q[3];

    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && has_req && !busy_q) |=> busy_q);
    assert_busy_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && has_req && busy_q) |=> err_q);
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_end_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(smp_stb));
    assert_avg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> $stable({avg_vc, avg_fe, avg_te, avg_rf}));
endmodule

// File: rtl/cal_sat_sub.sv
// Subtractor a - b for signed W-bit operands. CLIP_ZERO=0 gives a signed
// result saturated to the W-bit range. CLIP_ZERO=1 gives the unsigned
// excess of a over b, which is 0 when a <= b.
// Assumes: purely combinational; the caller registers the result.
module cal_sat_sub #(
    parameter int W         = 8,
    parameter bit CLIP_ZERO = 1'b0
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic [W-1:0]        y
);
    localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] MINV = {2'b11, {(W-1){1'b0}}};

    logic signed [W:0] diff;

    // Full-width difference, never wraps
    always_comb diff = {a[W-1], a} - {b[W-1], b};

    generate
        if (CLIP_ZERO) begin : g_clip
            // Non-negative excess only
            always_comb y = (diff > 0) ? diff[W-1:0] : '0;
        end else begin : g_sat
            // Clamp to the signed range
            always_comb begin
                if (diff > MAXV)      y = MAXV[W-1:0];
                else if (diff < MINV) y = MINV[W-1:0];
                else                  y = diff[W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/servo_offset_cal.sv
// Top of the servo offset calibration unit. It routes commands to the
// measurement engine or to the latched compensation enables. It picks the
// average each path subtracts and registers the four outputs on every
// sample strobe.
// Assumes: samples are valid in the strobe cycle; commands are one cycle.
module servo_offset_cal
    import servo_cal_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LOG2N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] vc_smp,
    input  logic signed [DW-1:0] fe_smp,
    input  logic signed [DW-1:0] te_smp,
    input  logic signed [DW-1:0] rf_smp,
    input  logic                 cmd_valid,
    input  logic                 cmd_is_comp,
    input  logic [CMD_W-1:0]     cmd_word,
    output logic                 sense,
    output logic                 cmd_err,
    output logic signed [DW-1:0] fcs_out,
    output logic signed [DW-1:0] trk_out,
    output logic signed [DW-1:0] fzc_out,
    output logic [DW-1:0]        rf_out
);
    comp_en_t              comp_q;
    logic                  meas_req;
    logic [3:0]            meas_bits;
    logic signed [DW-1:0]  avg_vc, avg_fe, avg_te, avg_rf;
    logic signed [DW-1:0]  trk_ref, fcs_ref;
    logic [DW-1:0]         trk_d, fcs_d, fzc_d, rf_d;
    logic signed [DW-1:0]  fcs_q, trk_q, fzc_q;
    logic [DW-1:0]         rf_q;

    // Measurement requests and their channel bits
    always_comb begin
        meas_req  = cmd_valid && !cmd_is_comp;
        meas_bits = {cmd_word[BIT_VC], cmd_word[BIT_FE],
                     cmd_word[BIT_RF], cmd_word[BIT_TE]};
    end

    cal_meas_engine #(.DW(DW), .LOG2N(LOG2N)) u_engine (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .vc_in(vc_smp), .fe_in(fe_smp), .te_in(te_smp), .rf_in(rf_smp),
        .meas_req(meas_req), .meas_bits(meas_bits),
        .busy(sense), .err(cmd_err),
        .avg_vc(avg_vc), .avg_fe(avg_fe), .avg_te(avg_te), .avg_rf(avg_rf)
    );

    // Latch the compensation enables on a compensation command
    always_ff @(posedge clk) begin
        if (!rst_n)                        comp_q <= '0;
        else if (cmd_valid && cmd_is_comp) comp_q <= comp_en_t'(cmd_word[COMP_W-1:0]);
    end

    // Reference select: the own-channel average wins over the centre average
    always_comb begin
        trk_ref = comp_q.trk_te ? avg_te : avg_vc;
        fcs_ref = comp_q.fcs_fe ? avg_fe : avg_vc;
    end

    cal_sat_sub #(.W(DW), .CLIP_ZERO(1'b0)) u_trk_sub (.a(te_smp), .b(trk_ref), .y(trk_d));
    cal_sat_sub #(.W(DW), .CLIP_ZERO(1'b0)) u_fcs_sub (.a(fe_smp), .b(fcs_ref), .y(fcs_d));
    cal_sat_sub #(.W(DW), .CLIP_ZERO(1'b0)) u_fzc_sub (.a(fe_smp), .b(avg_fe),  .y(fzc_d));
    cal_sat_sub #(.W(DW), .CLIP_ZERO(1'b1)) u_rf_sub  (.a(rf_smp), .b(avg_rf),  .y(rf_d));

    // Output registers, loaded once per sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcs_q <= '0;
            trk_q <= '0;
            fzc_q <= '0;
            rf_q  <= '0;
        end else if (smp_stb) begin
            fcs_q <= (comp_q.fcs_vc || comp_q.fcs_fe) ? $signed(fcs_d) : fe_smp;
            trk_q <= (comp_q.trk_vc || comp_q.trk_te) ? $signed(trk_d) : te_smp;
            fzc_q <= comp_q.fzc_fe  ? $signed(fzc_d) : fe_smp;
            rf_q  <= comp_q.rf_clip ? rf_d : rf_smp;
        end
    end

    assign fcs_out = fcs_q;
    assign trk_out = trk_q;
    assign fzc_out = fzc_q;
    assign rf_out  = rf_q;

    assert_rf_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && comp_q.rf_clip && (rf_smp <= avg_rf)) |=> (rf_out == '0));
    assert_fcs_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !comp_q.fcs_vc && !comp_q.fcs_fe) |=> (fcs_out == $past(fe_smp)));
    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable({fcs_out, trk_out, fzc_out, rf_out}));
endmodule

// File: tb/servo_offset_cal_test.sv
module servo_offset_cal_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [7:0]  vc_smp = '0, fe_smp = '0, te_smp = '0, rf_smp = '0;
    logic        cmd_valid = 1'b0, cmd_is_comp = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        sense, cmd_err;
    logic [7:0]  fcs_out, trk_out, fzc_out, rf_out;

    integer checks = 0;
    integer errors = 0;
    integer a_vc = 0, a_fe = 0, a_te = 0, a_rf = 0;

    always #2 clk = ~clk;

    servo_offset_cal uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .vc_smp(vc_smp), .fe_smp(fe_smp), .te_smp(te_smp), .rf_smp(rf_smp),
        .cmd_valid(cmd_valid), .cmd_is_comp(cmd_is_comp), .cmd_word(cmd_word),
        .sense(sense), .cmd_err(cmd_err),
        .fcs_out(fcs_out), .trk_out(trk_out), .fzc_out(fzc_out), .rf_out(rf_out)
    );

    function automatic integer sat8(input integer x);
        if (x > 127)       return 127;
        else if (x < -128) return -128;
        else               return x;
    endfunction

    function automatic integer s8(input logic [7:0] v);
        return $signed(v);
    endfunction

    task automatic chk(input string req, input integer got, input integer exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_cmd(input logic comp, input logic [15:0] w);
        cmd_valid = 1'b1; cmd_is_comp = comp; cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_is_comp = 1'b0; cmd_word = '0;
    endtask

    task automatic strobe(input integer v_vc, input integer v_fe, input integer v_te, input integer v_rf);
        vc_smp = v_vc[7:0]; fe_smp = v_fe[7:0]; te_smp = v_te[7:0]; rf_smp = v_rf[7:0];
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
    endtask

    // ch: 0 centre, 1 focus, 2 tracking, 3 RF. inj: 1 = busy measurement cmd, 2 = comp write 0x10
    task automatic measure(input logic [15:0] w, input integer ch, input integer base,
                           input integer inj, output integer avg);
        integer sum, high, p;
        integer v [4];
        sum = 0; high = 0;
        send_cmd(1'b0, w);
        chk("R4 sense rises", sense, 1);
        for (int i = 0; i < 256; i++) begin
            p = base + ((i * 7) % 9) - 4;
            for (int k = 0; k < 4; k++) v[k] = ((i * 13 + k * 31) % 256) - 128;
            v[ch] = p;
            sum += p;
            if (sense) high++;
            if (inj == 1 && i == 100) send_cmd(1'b0, 16'h2000);
            if (inj == 2 && i == 10)  send_cmd(1'b1, 16'h0010);
            strobe(v[0], v[1], v[2], v[3]);
        end
        chk("R4 sense falls after last strobe", sense, 0);
        chk("R4 sense length in strobes", high, 256);
        avg = sum >>> 8;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        integer dummy, exp_rf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 sense", sense, 0);
        chk("R12 cmd_err", cmd_err, 0);
        chk("R12 fcs_out", s8(fcs_out), 0);
        chk("R12 trk_out", s8(trk_out), 0);
        chk("R12 fzc_out", s8(fzc_out), 0);
        chk("R12 rf_out", rf_out, 0);

        // R2 command without a channel bit is ignored
        send_cmd(1'b0, 16'h0001);
        chk("R2 no channel bit", sense, 0);

        // R1 RF measurement, with a busy command injected (R3)
        measure(16'h0800, 3, 10, 1, a_rf);
        chk("R3 busy command flagged", cmd_err, 1);
        send_cmd(1'b1, 16'h0010);
        strobe(0, 33, 0, 0);
        chk("R3 dropped focus measurement left avg zero", s8(fcs_out), 33);

        // Focus measurement with a compensation write while busy (R11)
        measure(16'h2000, 1, 20, 2, a_fe);
        chk("R3 cmd_err sticky", cmd_err, 1);
        strobe(0, 5, 0, 0);
        chk("R11/R7 comp written while busy", s8(fcs_out), sat8(5 - a_fe));

        // R2 priority: bits 15, 11 and 4 set selects the centre channel only
        measure(16'h8810, 0, -3, 0, a_vc);
        send_cmd(1'b1, 16'h0004);
        strobe(0, 0, 7, 0);
        chk("R2 priority left tracking avg", s8(trk_out), 7);
        send_cmd(1'b1, 16'h0001);
        strobe(0, 0, 0, a_rf + 5);
        chk("R2 priority left RF avg", rf_out, 5);
        send_cmd(1'b1, 16'h0002);
        strobe(0, 0, 7, 0);
        chk("R2 priority measured centre", s8(trk_out), sat8(7 - a_vc));

        measure(16'h0010, 2, -50, 0, a_te);

        // R11 outputs hold between strobes
        send_cmd(1'b1, 16'h0000);
        strobe(11, 12, 13, 14);
        fe_smp = 8'd99; te_smp = 8'd98; rf_smp = 8'd97;
        repeat (3) @(negedge clk);
        chk("R11 fcs hold", s8(fcs_out), 12);
        chk("R11 trk hold", s8(trk_out), 13);
        chk("R11 rf hold", rf_out, 14);

        // R9 raw passthrough sweep
        for (int v = -128; v < 128; v++) begin
            strobe(0, v, v, v);
            chk("R9 fcs raw", s8(fcs_out), v);
            chk("R9 trk raw", s8(trk_out), v);
            chk("R9 fzc raw", s8(fzc_out), v);
            chk("R9 rf raw", rf_out, (v + 256) % 256);
        end

        // Centre-referenced paths, zero-cross and RF clip (R5 R6 R7 R8 R10)
        send_cmd(1'b1, 16'h0029);
        for (int v = -128; v < 128; v++) begin
            strobe(0, v, v, v);
            exp_rf = (v > a_rf) ? v - a_rf : 0;
            chk("R7 fcs minus centre", s8(fcs_out), sat8(v - a_vc));
            chk("R9 trk raw when off", s8(trk_out), v);
            chk("R8 fzc minus focus", s8(fzc_out), sat8(v - a_fe));
            chk("R5 rf clip", rf_out, exp_rf);
        end
        send_cmd(1'b1, 16'h0002);
        for (int v = -128; v < 128; v++) begin
            strobe(0, v, v, v);
            chk("R6 trk minus centre", s8(trk_out), sat8(v - a_vc));
        end

        // Own-channel averages, and both select bits set (R6 R7 R10)
        send_cmd(1'b1, 16'h0014);
        for (int v = -128; v < 128; v++) begin
            strobe(0, v, v, v);
            chk("R7 fcs minus focus", s8(fcs_out), sat8(v - a_fe));
            chk("R6 trk minus tracking", s8(trk_out), sat8(v - a_te));
        end
        send_cmd(1'b1, 16'h001E);
        for (int v = -128; v < 128; v++) begin
            strobe(0, v, v, v);
            chk("R7 focus select priority", s8(fcs_out), sat8(v - a_fe));
            chk("R6 tracking select priority", s8(trk_out), sat8(v - a_te));
        end
        strobe(0, 0, 127, 0);
        chk("R10 positive saturation", s8(trk_out), 127);
        dummy = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule